// File: doc/BRIEF.md
# Register-Mapped Pin Controller With Per-Pin Interrupts

This block drives and samples up to 32 general-purpose pins on behalf of a host that reaches it through a plain 32-bit register bus. Every pin owns one configuration word that decides whether the pin drives its pad, whether it is treated as an input, and whether and how it raises an interrupt. A shared output word holds the values the pins drive. A shared input word reports the pad levels once they have crossed a two-stage synchronizer.

Interrupt detection works per pin. A three-bit trigger code selects level-high, level-low, rising-edge, falling-edge or both-edge sensitivity. Detected events latch into a shared status word, and software clears it by writing ones. The single interrupt request line is high while any status bit is set. A build-time parameter moves the input and output data words to a second pair of offsets, so the block can match either of two register maps.

Top module: `gpio_irq_bank`

## Requirements
- R1: After a synchronous active-low reset, every configuration word, the output word and the status word read as zero, and `pin_out`, `pin_oe` and `irq` are all zero.
- R2: The configuration word of pin i sits at byte offset 4*i for i below NUM_PINS. It keeps bits 0, 1, 2, 3 and 7:5 of a write, and every other bit reads as zero. Read data appears on `bus_rdata` one clock after `bus_rd_en` is sampled. Any offset without a register, any offset whose two low bits are not zero, and every offset above 0xA3 reads as zero and ignores writes.
- R3: `pin_oe[i]` is high exactly when bit 0 (drive enable) and bit 2 (pad buffer enable) of pin i's configuration word are both set.
- R4: A write to the output word stores one bit per pin, `pin_out` follows the stored bits, and a read returns them.
- R5: A read of the input word returns the pad levels as seen after a two-flop synchronizer. A level applied just before a read is not yet visible in that read. Writes to the input word have no effect.
- R6: With ALT_DATA_MAP = 0 the input word is at 0x84 and the output word at 0x88. With ALT_DATA_MAP = 1 they are at 0x90 and 0xA0, and 0x84 and 0x88 are unmapped.
- R7: Trigger code in configuration bits 7:5: 0 fires while the synchronized level is high, 1 while it is low, 2 on a rising edge, 3 on a falling edge, 4 on either edge, and 5 to 7 never fire. An edge is the synchronized level compared with its value one clock earlier.
- R8: A status bit can only become set while that pin's interrupt enable (configuration bit 3) is 1.
- R9: The status word is at 0x80, and bit i belongs to pin i. Writing 1 to a bit clears it and writing 0 leaves it unchanged. A level trigger whose level is still active sets the bit again at once.
- R10: When a new event and a clearing write hit the same bit in the same cycle, the bit stays set.
- R11: `irq` is high exactly when at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_rd_en | input | 1 | Read strobe, data returned next cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Pad levels, asynchronous to clk |
| pin_out | output | NUM_PINS | Values driven towards the pads |
| pin_oe | output | NUM_PINS | Pad drive enables |
| irq | output | 1 | Interrupt request, OR of the status word |

## Verification
The bench builds two copies of the block side by side on one bus. One uses the defaults (32 pins, ALT_DATA_MAP = 0). The other uses NUM_PINS = 12 with ALT_DATA_MAP = 1. The full-width copy exercises every configuration offset and the whole status word, so the top pin and the 0x7C boundary are reached. The narrow copy checks the alternate data offsets, shows that configuration offsets above its last pin read as zero, and confirms that the default data offsets are dead in that map. Because the bus is shared, each copy's unmapped ranges are tested by writes aimed at the other copy.

// File: rtl/gpio_bank_pkg.sv
// Package: shared types and helpers for the pin controller.
// Assumes at most 32 pins and an 8-bit byte address space.
package gpio_bank_pkg;

    localparam int unsigned MAX_PINS = 32;
    localparam int unsigned REG_W    = 32;
    localparam int unsigned ADDR_W   = 8;

    // Trigger codes held in configuration bits 7:5.
    typedef enum logic [2:0] {
        TRIG_LVL_HI = 3'd0,
        TRIG_LVL_LO = 3'd1,
        TRIG_RISE   = 3'd2,
        TRIG_FALL   = 3'd3,
        TRIG_BOTH   = 3'd4
    } trig_e;

    // Stored part of one pin's configuration word.
    typedef struct packed {
        logic [2:0] trig;
        logic       irq_en;
        logic       buf_en;
        logic       rx_en;
        logic       tx_en;
    } pin_cfg_t;

    // Place a stored configuration back into its 32-bit register image.
    function automatic logic [REG_W-1:0] cfg_to_word(pin_cfg_t c);
        return {24'd0, c.trig, 1'b0, c.irq_en, c.buf_en, c.rx_en, c.tx_en};
    endfunction

    // Decide whether a trigger code fires for the current and previous level.
    function automatic logic trig_hit(logic [2:0] t, logic now, logic was);
        logic hit;
        case (t)
            TRIG_LVL_HI: hit = now;
            TRIG_LVL_LO: hit = !now;
            TRIG_RISE:   hit = now & !was;
            TRIG_FALL:   hit = !now & was;
            TRIG_BOTH:   hit = now ^ was;
            default:     hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
// Module: two-flop synchronizer for the pad levels plus a one-cycle
// history stage used for edge detection.
// Assumes pin_i may change at any time relative to clk.
module gpio_in_sync #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] sync_o,
    output logic [N-1:0] prev_o
);

    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;
    logic [N-1:0] prev_q;

    // Shift pad levels through the synchronizer and the history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign sync_o = sync_q;
    assign prev_o = prev_q;

endmodule

// File: rtl/gpio_pin_slot.sv
// Module: one pin's configuration register and its event detector.
// Assumes lvl_i/lvl_prev_i are already synchronized to clk.
module gpio_pin_slot
    import gpio_bank_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_i,
    input  pin_cfg_t cfg_wr_i,
    input  logic     lvl_i,
    input  logic     lvl_prev_i,
    output pin_cfg_t cfg_o,
    output logic     evt_o
);

    pin_cfg_t cfg_q;

    // Hold the pin configuration, loaded by a bus write to this slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_i) begin
            cfg_q <= cfg_wr_i;
        end
    end

    // Raise an event when enabled and the selected trigger condition holds.
    always_comb begin
        evt_o = cfg_q.irq_en & trig_hit(cfg_q.trig, lvl_i, lvl_prev_i);
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/gpio_irq_status.sv
// Module: interrupt status word with write-one-to-clear and the OR-ed
// request line. Assumes evt_i and clr_i are single-cycle vectors.
module gpio_irq_status #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] status_o,
    output logic         irq_o
);

    logic [N-1:0] status_q;

    // Latch new events; a clear only removes bits without a new event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_i) | evt_i;
        end
    end

    // Request line is high while any flag is pending.
    always_comb begin
        irq_o = |status_q;
    end

    assign status_o = status_q;

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_i) |=> ((status_q & $past(clr_i & ~evt_i)) == '0))
        else $error("cleared bit still set"); // R9

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> (($past(evt_i) & ~status_q) == '0))
        else $error("event lost"); // R10

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt_i)) == '0))
        else $error("flag set without event"); // R7

endmodule

// File: rtl/gpio_irq_bank.sv
// Module: top of the register-mapped pin controller. Decodes the
// register bus, holds the output word, and ties per-pin slots, the input
// synchronizer and the status word together.
// Assumes one access per strobe cycle and NUM_PINS in 1..32.
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_PINS     = 32,
    parameter bit          ALT_DATA_MAP = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr_en,
    input  logic                bus_rd_en,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);

    localparam logic [ADDR_W-3:0] STAT_WIX = 6'h20;
    localparam logic [ADDR_W-3:0] IN_WIX   = ALT_DATA_MAP ? 6'h24 : 6'h21;
    localparam logic [ADDR_W-3:0] OUT_WIX  = ALT_DATA_MAP ? 6'h28 : 6'h22;

    logic [ADDR_W-3:0]   wix;
    logic                aligned;
    pin_cfg_t            cfg_wr;
    pin_cfg_t            cfg_arr [NUM_PINS];
    logic [NUM_PINS-1:0] evt_vec;
    logic [NUM_PINS-1:0] irq_en_vec;
    logic [NUM_PINS-1:0] sync_lvl;
    logic [NUM_PINS-1:0] prev_lvl;
    logic [NUM_PINS-1:0] status;
    logic [NUM_PINS-1:0] clr_vec;
    logic [NUM_PINS-1:0] out_q;
    logic [REG_W-1:0]    rd_word;

    assign wix     = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);

    // Split the write data into the stored configuration fields.
    always_comb begin
        cfg_wr.trig   = bus_wdata[7:5];
        cfg_wr.irq_en = bus_wdata[3];
        cfg_wr.buf_en = bus_wdata[2];
        cfg_wr.rx_en  = bus_wdata[1];
        cfg_wr.tx_en  = bus_wdata[0];
    end

    gpio_in_sync #(.N(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_in),
        .sync_o (sync_lvl),
        .prev_o (prev_lvl)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic slot_wr;
        assign slot_wr = bus_wr_en && aligned && (wix == (ADDR_W-2)'(i));

        gpio_pin_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_i       (slot_wr),
            .cfg_wr_i   (cfg_wr),
            .lvl_i      (sync_lvl[i]),
            .lvl_prev_i (prev_lvl[i]),
            .cfg_o      (cfg_arr[i]),
            .evt_o      (evt_vec[i])
        );

        assign pin_oe[i]     = cfg_arr[i].tx_en & cfg_arr[i].buf_en;
        assign irq_en_vec[i] = cfg_arr[i].irq_en;
    end

    // Clear mask is the write data of a write to the status word.
    always_comb begin
        clr_vec = '0;
        if (bus_wr_en && aligned && (wix == STAT_WIX)) begin
            clr_vec = bus_wdata[NUM_PINS-1:0];
        end
    end

    gpio_irq_status #(.N(NUM_PINS)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_vec),
        .clr_i    (clr_vec),
        .status_o (status),
        .irq_o    (irq)
    );

    // Hold the driven values, loaded by a write to the output word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (bus_wr_en && aligned && (wix == OUT_WIX)) begin
            out_q <= bus_wdata[NUM_PINS-1:0];
        end
    end

    assign pin_out = out_q;

    // Select the register image addressed by the bus; unmapped reads give 0.
    always_comb begin
        rd_word = '0;
        if (aligned) begin
            if (wix == STAT_WIX) begin
                rd_word = REG_W'(status);
            end else if (wix == IN_WIX) begin
                rd_word = REG_W'(sync_lvl);
            end else if (wix == OUT_WIX) begin
                rd_word = REG_W'(out_q);
            end else begin
                for (int k = 0; k < NUM_PINS; k++) begin
                    if (wix == (ADDR_W-2)'(k)) begin
                        rd_word = cfg_to_word(cfg_arr[k]);
                    end
                end
            end
        end
    end

    // Register read data so it is stable one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd_en) begin
            bus_rdata <= rd_word;
        end
    end

    AST_FLAG_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(irq_en_vec)) == '0))
        else $error("flag set on disabled pin"); // R8

    AST_HIGH_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && (bus_addr > 8'hA3)) |=> (bus_rdata == '0))
        else $error("unmapped read not zero"); // R2

endmodule

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;

    localparam int CLK_PERIOD = 10;
    localparam int ALT_PINS   = 12;
    localparam logic [31:0] CFG_MASK = 32'h0000_00EF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata_m;
    logic [31:0] rdata_a;
    logic [31:0] pin_in = '0;
    logic [31:0] pout_m;
    logic [31:0] poe_m;
    logic        irq_m;
    logic [ALT_PINS-1:0] pout_a;
    logic [ALT_PINS-1:0] poe_a;
    logic        irq_a;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;
    logic [31:0] exp_cfg [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_bank i_gpio_irq_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_m),
        .pin_in(pin_in), .pin_out(pout_m), .pin_oe(poe_m), .irq(irq_m)
    );

    gpio_irq_bank #(.NUM_PINS(ALT_PINS), .ALT_DATA_MAP(1'b1)) i_gpio_irq_bank_alt (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
        .pin_in(pin_in[ALT_PINS-1:0]), .pin_out(pout_a), .pin_oe(poe_a), .irq(irq_a)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] dm, output logic [31:0] da);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd_en = 1'b0;
        dm = rdata_m; da = rdata_a;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected flag after: level L stable, enable, clear, then level M.
    function automatic logic exp_flag(input int t, input logic l, input logic m);
        case (t)
            0: return l | m;
            1: return !l | !m;
            2: return !l & m;
            3: return l & !m;
            4: return l ^ m;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] exp_oe();
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = exp_cfg[i][0] & exp_cfg[i][2];
        return r;
    endfunction

    task automatic wipe();
        for (int i = 0; i < 32; i++) begin
            bus_write(8'(4*i), 32'h0);
            exp_cfg[i] = '0;
        end
        bus_write(8'h80, 32'hFFFF_FFFF);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] dm, da, v, old_in;
        int unsigned seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < 32; i++) exp_cfg[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pin_oe", poe_m, 32'h0);
        check("R1 pin_out", pout_m, 32'h0);
        check("R1 irq", {31'd0, irq_m}, 32'h0);
        bus_read(8'h80, dm, da); check("R1 status", dm, 32'h0);
        bus_read(8'h14, dm, da); check("R1 cfg", dm, 32'h0);
        bus_read(8'h88, dm, da); check("R1 outword", dm, 32'h0);

        // R2 R3 random configuration writes
        for (int n = 0; n < 24; n++) begin
            int p;
            p = int'($urandom_range(31, 0));
            v = $urandom();
            v[3] = 1'b0;
            bus_write(8'(4*p), v);
            exp_cfg[p] = v & CFG_MASK;
            bus_read(8'(4*p), dm, da);
            check("R2 cfg readback", dm, exp_cfg[p]);
            check("R3 pin_oe", poe_m, exp_oe());
        end
        bus_write(8'h7C, 32'hFFFF_FFF5);
        exp_cfg[31] = 32'h0000_00E5;
        bus_read(8'h7C, dm, da); check("R2 top pin cfg", dm, 32'h0000_00E5);
        check("R3 top pin oe", {31'd0, poe_m[31]}, 32'd1);
        bus_write(8'h7C, 32'h0000_0001);
        exp_cfg[31] = 32'h1;
        check("R3 oe needs buffer", {31'd0, poe_m[31]}, 32'd0);

        // R2 unmapped and unaligned
        bus_write(8'h30, 32'h0000_00FF);
        bus_read(8'h30, dm, da); check("R2 alt cfg beyond pins", da, 32'h0);
        bus_write(8'h31, 32'h0000_0001);
        bus_read(8'h30, dm, da); check("R2 unaligned write ignored", dm, 32'h0000_00EF);
        exp_cfg[12] = 32'hEF;
        bus_read(8'h31, dm, da); check("R2 unaligned read", dm, 32'h0);
        bus_read(8'hB0, dm, da); check("R2 high offset", dm, 32'h0);
        bus_read(8'hFC, dm, da); check("R2 top offset", dm, 32'h0);
        wipe();

        // R4 R6 output word
        for (int n = 0; n < 6; n++) begin
            v = $urandom();
            bus_write(8'h88, v);
            check("R4 pin_out", pout_m, v);
            bus_read(8'h88, dm, da);
            check("R4 outword read", dm, v);
            check("R6 alt ignores 0x88", da, 32'h0);
            check("R6 alt pin_out untouched", 32'(pout_a), 32'h0);
        end
        v = $urandom();
        bus_write(8'hA0, v);
        check("R6 alt pin_out", 32'(pout_a), {20'd0, v[11:0]});
        bus_read(8'hA0, dm, da);
        check("R6 alt outword", da, {20'd0, v[11:0]});
        check("R6 main 0xA0 unmapped", dm, 32'h0);

        // R5 R6 input word with synchronizer latency
        for (int n = 0; n < 6; n++) begin
            @(negedge clk);
            old_in = pin_in;
            pin_in = $urandom();
            bus_read(8'h84, dm, da);
            check("R5 not yet visible", dm, old_in);
            bus_read(8'h84, dm, da);
            check("R5 input word", dm, pin_in);
            bus_read(8'h90, dm, da);
            check("R6 alt input word", da, {20'd0, pin_in[11:0]});
        end
        bus_write(8'h84, 32'h0);
        bus_read(8'h84, dm, da);
        check("R5 write ignored", dm, pin_in);
        @(negedge clk); pin_in = '0; idle(4);
        bus_write(8'h80, 32'hFFFF_FFFF);

        // R7 random trigger trials
        for (int n = 0; n < 24; n++) begin
            int p, t;
            logic l, m;
            p = int'($urandom_range(31, 0));
            t = (n < 16) ? int'($urandom_range(4, 0)) : int'($urandom_range(7, 0));
            l = 1'($urandom());
            m = 1'($urandom());
            @(negedge clk); pin_in[p] = l; idle(4);
            bus_write(8'(4*p), 32'h0000_000A | (32'(t) << 5));
            bus_write(8'h80, 32'hFFFF_FFFF);
            @(negedge clk); pin_in[p] = m; idle(4);
            bus_read(8'h80, dm, da);
            check($sformatf("R7 trig=%0d %0d->%0d", t, l, m), dm, 32'(exp_flag(t, l, m)) << p);
            check("R11 irq follows status", {31'd0, irq_m}, {31'd0, |dm});
            bus_write(8'(4*p), 32'h0);
            bus_write(8'h80, 32'hFFFF_FFFF);
            @(negedge clk); pin_in = '0; idle(4);
            bus_write(8'h80, 32'hFFFF_FFFF);
        end

        // R8 disabled interrupt: rising edge with bit 3 clear
        bus_write(8'h14, 32'h0000_0042);
        @(negedge clk); pin_in[5] = 1'b1; idle(4);
        bus_read(8'h80, dm, da); check("R8 disabled no flag", dm, 32'h0);
        bus_write(8'h14, 32'h0000_004A);
        idle(3);
        bus_read(8'h80, dm, da); check("R8 enable without edge", dm, 32'h0);
        check("R11 irq low", {31'd0, irq_m}, 32'h0);

        // R9 W1C on edge flag, level re-set
        @(negedge clk); pin_in[5] = 1'b0; idle(3);
        @(negedge clk); pin_in[5] = 1'b1; idle(4);
        bus_read(8'h80, dm, da); check("R9 rise flag", dm, 32'h20);
        check("R11 irq high", {31'd0, irq_m}, 32'h1);
        bus_write(8'h80, 32'h0);
        bus_read(8'h80, dm, da); check("R9 write zero keeps", dm, 32'h20);
        bus_write(8'h80, 32'hFFFF_FFDF);
        bus_read(8'h80, dm, da); check("R9 other bits keep", dm, 32'h20);
        bus_write(8'h80, 32'h20);
        bus_read(8'h80, dm, da); check("R9 clear edge flag", dm, 32'h0);
        check("R11 irq dropped", {31'd0, irq_m}, 32'h0);
        bus_write(8'h14, 32'h0000_000A);
        bus_write(8'h80, 32'h20);
        bus_read(8'h80, dm, da); check("R9 level re-sets", dm, 32'h20);
        @(negedge clk); pin_in[5] = 1'b0; idle(4);
        bus_write(8'h80, 32'h20);
        bus_read(8'h80, dm, da); check("R9 level gone clears", dm, 32'h0);

        // R10 event and clear in the same cycle (both-edge trigger)
        bus_write(8'h14, 32'h0000_008A);
        @(negedge clk); pin_in[5] = 1'b1; idle(4);
        bus_read(8'h80, dm, da); check("R10 first edge", dm, 32'h20);
        @(negedge clk); pin_in[5] = 1'b0;
        @(negedge clk);
        bus_write(8'h80, 32'h20);
        bus_read(8'h80, dm, da); check("R10 event beats clear", dm, 32'h20);
        check("R11 irq held", {31'd0, irq_m}, 32'h1);
        bus_write(8'h80, 32'h20);
        bus_read(8'h80, dm, da); check("R10 later clear works", dm, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule